// File: doc/BRIEF.md
# Glitch-Free System Clock Switch

This block chooses which of two free-running, mutually asynchronous sources drives the main system clock. One source is a slow clock at a quarter of the low-frequency oscillator rate. The other is the fast gear clock. A select bit from the clock control register names the wanted source: 1 for the slow clock, 0 for the gear clock. When the select bit changes, the active source runs out its current pulse and is parked low. The other source is then let through only after it has seen the parked state. The output therefore never shows a shortened pulse or an overlap of the two sources.

Handshake and misuse logic run on a control clock whose period is one machine cycle. Two kinds of misuse cause a one-cycle system-clock reset pulse. The first is turning off the slow oscillator too soon after leaving the slow clock. The second is turning on the fast oscillator while its pins are not set up as oscillator pins. Status outputs show which source is active and whether a handover is still running. A select change that arrives during a handover is held back until that handover ends.

Top module: `sysclk_switch`

## Requirements
- R1: While `rst` is high and after it is released with the select bit at 1, the slow source drives `clk_main`, `src_is_lf` is 1, `src_is_gear` is 0, `switch_busy` is 0 and `clk_sys_rst` is 0.
- R2: Once settled on the slow source, every rising edge of `clk_main` coincides with a rising edge of `clk_lf` and never with one of `clk_gear`; once settled on the gear source, the reverse holds.
- R3: A select change from 1 to 0 hands the output to the gear clock; a change from 0 to 1 hands it back to the slow clock. The status settles on the new source.
- R4: The outgoing source is stopped after two of its own rising edges have seen the request. The incoming source starts after two of its own rising edges have seen the stop. As a result, the output low gap during a handover is at most three periods of the incoming clock.
- R5: `clk_sys_rst` pulses high for exactly one control cycle when `lf_osc_en` is seen falling in the same control cycle as the 1-to-0 select change, or in the next cycle. A fall two or more cycles later, or with no select change, gives no pulse.
- R6: `clk_sys_rst` pulses high for exactly one control cycle when `hf_osc_en` is seen rising while `osc_pin_fn` is 0. A rise with `osc_pin_fn` at 1, or a drop of `osc_pin_fn` while `hf_osc_en` stays 1, gives no pulse.
- R7: `switch_busy` is 1 from the control cycle after the select change is taken until both status flags show the new source. While it is 0, exactly one of `src_is_lf` and `src_is_gear` is 1.
- R8: A select change made while `switch_busy` is 1 does not stop the current handover. It is acted on only after that handover has finished.
- R9: Every high phase and every low phase of `clk_main` lasts at least the shorter source half period. The two source gates are never open at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, one machine cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| clk_lf | input | 1 | Quarter-rate low-frequency source clock |
| clk_gear | input | 1 | High-frequency gear source clock |
| sel_lf | input | 1 | Source select: 1 slow clock, 0 gear clock |
| lf_osc_en | input | 1 | Low-frequency oscillator enable bit |
| hf_osc_en | input | 1 | High-frequency oscillator enable bit |
| osc_pin_fn | input | 1 | Pins set up as oscillator pins when 1 |
| clk_main | output | 1 | Gated main system clock |
| src_is_lf | output | 1 | Slow clock is driving the output |
| src_is_gear | output | 1 | Gear clock is driving the output |
| switch_busy | output | 1 | Handover in progress |
| clk_sys_rst | output | 1 | One-cycle system-clock reset pulse on misuse |

## Verification
The assertions assume several things about the inputs. The control bits change only between rising edges of `clk`. Reset is held long enough for at least three edges of each source clock. Both sources run freely and never stop. The bench meets these assumptions: it drives every control bit at the falling edge of `clk` and holds reset for forty control cycles. It also gives the two sources periods of 66 ns and 10 ns, with rising edges that never coincide, so each output rising edge can be traced to one source by its timestamp.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef struct packed {
        logic lf_on;
        logic gear_on;
        logic busy;
    } clksw_stat_t;

    // true when the synchronised gate states match the wanted source alone
    function automatic logic handover_done(input logic want_lf,
                                           input logic lf_on,
                                           input logic gear_on);
        return want_lf ? (lf_on && !gear_on) : (gear_on && !lf_on);
    endfunction

    function automatic int unsigned guard_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) ff <= INIT;
                else     ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= {STAGES{INIT}};
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/clksw_branch.sv
module clksw_branch #(
    parameter int   STAGES      = 2,
    parameter logic ON_AT_RESET = 1'b0
) (
    input  logic src_clk,
    input  logic rst,
    input  logic want,
    input  logic other_on,
    output logic gate_on,
    output logic clk_gated
);
    logic want_s;
    logic other_s;
    logic gate_q;

    clksw_sync #(.STAGES(STAGES), .INIT(ON_AT_RESET)) u_want (
        .clk(src_clk), .rst(rst), .d(want), .q(want_s)
    );

    clksw_sync #(.STAGES(STAGES), .INIT(!ON_AT_RESET)) u_other (
        .clk(src_clk), .rst(rst), .d(other_on), .q(other_s)
    );

    // gate changes only while the source is low: no runt pulse
    always_ff @(negedge src_clk) begin
        if (rst) gate_q <= ON_AT_RESET;
        else     gate_q <= want_s && (gate_q || !other_s);
    end

    assign gate_on   = gate_q;
    assign clk_gated = src_clk & gate_q;
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int   STAGES      = 2,
    parameter logic RESET_TO_LF = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_lf,
    input  logic        lf_gate,
    input  logic        gear_gate,
    output logic        tgt_lf,
    output clksw_stat_t stat
);
    logic lf_on_s;
    logic gear_on_s;
    logic tgt_q;
    logic settled;

    clksw_sync #(.STAGES(STAGES), .INIT(RESET_TO_LF)) u_lf_stat (
        .clk(clk), .rst(rst), .d(lf_gate), .q(lf_on_s)
    );

    clksw_sync #(.STAGES(STAGES), .INIT(!RESET_TO_LF)) u_gear_stat (
        .clk(clk), .rst(rst), .d(gear_gate), .q(gear_on_s)
    );

    assign settled = handover_done(tgt_q, lf_on_s, gear_on_s);

    // a new select is taken only between handovers
    always_ff @(posedge clk) begin
        if (rst)          tgt_q <= RESET_TO_LF;
        else if (settled) tgt_q <= sel_lf;
    end

    always_comb begin
        stat.lf_on   = lf_on_s;
        stat.gear_on = gear_on_s;
        stat.busy    = !settled;
    end

    assign tgt_lf = tgt_q;

    p_hold_target_r8: assert property (@(posedge clk) disable iff (rst)
        stat.busy |=> $stable(tgt_q));

    p_idle_one_source_r7: assert property (@(posedge clk) disable iff (rst)
        !stat.busy |-> $onehot({stat.lf_on, stat.gear_on}));
endmodule

// File: rtl/clksw_guard.sv
module clksw_guard
    import clksw_pkg::*;
#(
    parameter int unsigned GUARD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_lf,
    input  logic lf_en,
    input  logic hf_en,
    input  logic pin_osc,
    output logic clk_rst
);
    localparam int unsigned W = guard_width(GUARD_CYCLES);

    logic         sel_q, lf_q, hf_q;
    logic [W-1:0] win;
    logic         sel_fall, lf_fall, hf_rise;
    logic         too_early, pin_bad;

    assign sel_fall  = sel_q && !sel_lf;
    assign lf_fall   = lf_q && !lf_en;
    assign hf_rise   = !hf_q && hf_en;
    assign too_early = lf_fall && (sel_fall || (win != '0));
    assign pin_bad   = hf_rise && !pin_osc;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b1;
            lf_q    <= 1'b1;
            hf_q    <= 1'b0;
            win     <= '0;
            clk_rst <= 1'b0;
        end else begin
            sel_q   <= sel_lf;
            lf_q    <= lf_en;
            hf_q    <= hf_en;
            if (sel_fall)         win <= W'(GUARD_CYCLES - 1);
            else if (win != '0)   win <= win - 1'b1;
            clk_rst <= too_early || pin_bad;
        end
    end

    p_early_same_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(sel_lf) && $fell(lf_en)) |=> clk_rst);

    generate
        if (GUARD_CYCLES >= 2) begin : g_next_chk
            p_early_next_cycle_r5: assert property (@(posedge clk) disable iff (rst)
                ($fell(lf_en) && $past($fell(sel_lf))) |=> clk_rst);
        end
    endgenerate

    p_pin_misuse_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(hf_en) && !pin_osc) |=> clk_rst);
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
    import clksw_pkg::*;
#(
    parameter int          SYNC_STAGES  = 2,
    parameter int unsigned GUARD_CYCLES = 2,
    parameter logic        RESET_TO_LF  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_lf,
    input  logic clk_gear,
    input  logic sel_lf,
    input  logic lf_osc_en,
    input  logic hf_osc_en,
    input  logic osc_pin_fn,
    output logic clk_main,
    output logic src_is_lf,
    output logic src_is_gear,
    output logic switch_busy,
    output logic clk_sys_rst
);
    logic        tgt_lf;
    logic        lf_gate, gear_gate;
    logic        lf_clk_g, gear_clk_g;
    clksw_stat_t stat;

    clksw_ctrl #(.STAGES(SYNC_STAGES), .RESET_TO_LF(RESET_TO_LF)) u_ctrl (
        .clk(clk), .rst(rst), .sel_lf(sel_lf),
        .lf_gate(lf_gate), .gear_gate(gear_gate),
        .tgt_lf(tgt_lf), .stat(stat)
    );

    clksw_branch #(.STAGES(SYNC_STAGES), .ON_AT_RESET(RESET_TO_LF)) u_lf (
        .src_clk(clk_lf), .rst(rst), .want(tgt_lf), .other_on(gear_gate),
        .gate_on(lf_gate), .clk_gated(lf_clk_g)
    );

    clksw_branch #(.STAGES(SYNC_STAGES), .ON_AT_RESET(!RESET_TO_LF)) u_gear (
        .src_clk(clk_gear), .rst(rst), .want(!tgt_lf), .other_on(lf_gate),
        .gate_on(gear_gate), .clk_gated(gear_clk_g)
    );

    clksw_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
        .clk(clk), .rst(rst), .sel_lf(sel_lf), .lf_en(lf_osc_en),
        .hf_en(hf_osc_en), .pin_osc(osc_pin_fn), .clk_rst(clk_sys_rst)
    );

    assign clk_main    = lf_clk_g | gear_clk_g;
    assign src_is_lf   = stat.lf_on;
    assign src_is_gear = stat.gear_on;
    assign switch_busy = stat.busy;

    p_gates_exclusive_gear_r9: assert property (@(posedge clk_gear) disable iff (rst)
        !(lf_gate && gear_gate));

    p_gates_exclusive_lf_r9: assert property (@(posedge clk_lf) disable iff (rst)
        !(lf_gate && gear_gate));
endmodule

// File: tb/sysclk_switch_test.sv
`timescale 1ns/1ps
module sysclk_switch_test;
    localparam int  T_GEAR = 10;
    localparam int  T_LF   = 66;
    localparam int  HALF_MIN = 5;
    localparam longint WD_NS = 200000 * 8;

    logic clk = 0, rst = 1, clk_lf = 0, clk_gear = 0;
    logic sel_lf = 1, lf_osc_en = 1, hf_osc_en = 0, osc_pin_fn = 1;
    logic clk_main, src_is_lf, src_is_gear, switch_busy, clk_sys_rst;

    int checks = 0, fails = 0;
    bit done = 0, mon_en = 0;

    sysclk_switch uut (
        .clk(clk), .rst(rst), .clk_lf(clk_lf), .clk_gear(clk_gear),
        .sel_lf(sel_lf), .lf_osc_en(lf_osc_en), .hf_osc_en(hf_osc_en),
        .osc_pin_fn(osc_pin_fn), .clk_main(clk_main), .src_is_lf(src_is_lf),
        .src_is_gear(src_is_gear), .switch_busy(switch_busy),
        .clk_sys_rst(clk_sys_rst)
    );

    always #4 clk = ~clk;
    always #5 clk_gear = ~clk_gear;            // rises at 5 mod 10
    initial begin #1; forever #33 clk_lf = ~clk_lf; end  // rises at even ns

    // output monitor
    longint last_rise = 0, last_fall = 0;
    bit     have_rise = 0, have_fall = 0, prev_gear = 0, have_prev = 0;
    longint min_high = 1000, min_low = 1000, gap_to_gear = -1, gap_to_lf = -1;
    int     n_rise_lf = 0, n_rise_gear = 0, rst_pulses = 0;
    bit     saw_lf = 0;

    always @(posedge clk_main) if (mon_en) begin
        longint t;
        longint low_len;
        bit is_gear;
        t = $time;
        is_gear = ((t % 10) == 5);
        if (have_fall) begin
            low_len = t - last_fall;
            if (low_len < min_low) min_low = low_len;
            if (have_prev && is_gear && !prev_gear) gap_to_gear = low_len;
            if (have_prev && !is_gear && prev_gear) gap_to_lf = low_len;
        end
        if (is_gear) n_rise_gear++; else n_rise_lf++;
        prev_gear = is_gear; have_prev = 1;
        last_rise = t; have_rise = 1;
    end

    always @(negedge clk_main) if (mon_en) begin
        if (have_rise && ($time - last_rise) < min_high) min_high = $time - last_rise;
        last_fall = $time; have_fall = 1;
    end

    always @(negedge clk) if (mon_en) begin
        if (clk_sys_rst) rst_pulses++;
        if (src_is_lf) saw_lf = 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        int quiet = 0;
        int spent = 0;
        while (quiet < 4 && spent < 3000) begin
            @(negedge clk);
            spent++;
            if (switch_busy) quiet = 0; else quiet++;
        end
        check(quiet >= 4, req, "handover did not finish", spent, 3000);
    endtask

    task automatic go_source(input logic lf);
        @(negedge clk);
        sel_lf = lf;
        cycles(2);
        wait_idle("R3");
    endtask

    initial begin
        #(WD_NS);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int p0;
        cycles(40);
        // R1: state during reset
        check(src_is_lf === 1 && src_is_gear === 0 && switch_busy === 0 && clk_sys_rst === 0,
              "R1", "reset state flags", {src_is_lf, src_is_gear, switch_busy, clk_sys_rst}, 4'b1000);
        rst = 0;
        mon_en = 1;
        cycles(20);
        check(src_is_lf === 1 && src_is_gear === 0 && switch_busy === 0,
              "R1", "state after release", {src_is_lf, src_is_gear, switch_busy}, 3'b100);

        // R2: slow source drives output
        n_rise_lf = 0; n_rise_gear = 0;
        #1000;
        check(n_rise_gear == 0, "R2", "gear edges while on slow clock", n_rise_gear, 0);
        check(n_rise_lf >= 14, "R2", "slow edges while on slow clock", n_rise_lf, 15);

        // R3/R7: switch to gear
        @(negedge clk); sel_lf = 0;
        cycles(2);
        check(switch_busy === 1, "R7", "busy after select change", switch_busy, 1);
        wait_idle("R3");
        check(src_is_gear === 1 && src_is_lf === 0, "R3", "gear active after switch",
              {src_is_lf, src_is_gear}, 2'b01);
        check(gap_to_gear > 0 && gap_to_gear <= 3 * T_GEAR, "R4", "gap into gear", gap_to_gear, 3 * T_GEAR);
        n_rise_lf = 0; n_rise_gear = 0;
        #500;
        check(n_rise_lf == 0 && n_rise_gear >= 45, "R2", "gear drives output (slow edges seen)",
              n_rise_lf, 0);

        // R3/R4: back to slow clock
        go_source(1);
        check(src_is_lf === 1 && src_is_gear === 0, "R3", "slow active after reverse",
              {src_is_lf, src_is_gear}, 2'b10);
        check(gap_to_lf > 0 && gap_to_lf <= 3 * T_LF, "R4", "gap into slow clock", gap_to_lf, 3 * T_LF);
        check(rst_pulses == 0, "R5", "no pulse from plain switching", rst_pulses, 0);

        // R8: select flips back during handover
        saw_lf = 0;
        go_source(0);
        @(negedge clk); sel_lf = 1;
        cycles(3);
        check(switch_busy === 1, "R7", "busy during handover", switch_busy, 1);
        sel_lf = 0;
        saw_lf = 0;
        wait_idle("R8");
        check(saw_lf == 1, "R8", "held handover reached slow clock", saw_lf, 1);
        check(src_is_gear === 1 && src_is_lf === 0, "R8", "held select applied afterwards",
              {src_is_lf, src_is_gear}, 2'b01);
        go_source(1);

        // R5: oscillator off in the same cycle as the select change
        p0 = rst_pulses;
        @(negedge clk); sel_lf = 0; lf_osc_en = 0;
        cycles(4);
        check(rst_pulses == p0 + 1, "R5", "pulse, same cycle", rst_pulses - p0, 1);
        wait_idle("R3");
        @(negedge clk); lf_osc_en = 1;
        go_source(1);

        // R5: one cycle later
        p0 = rst_pulses;
        @(negedge clk); sel_lf = 0;
        @(negedge clk); lf_osc_en = 0;
        cycles(4);
        check(rst_pulses == p0 + 1, "R5", "pulse, next cycle", rst_pulses - p0, 1);
        wait_idle("R3");
        @(negedge clk); lf_osc_en = 1;
        go_source(1);

        // R5: two cycles later is allowed
        p0 = rst_pulses;
        @(negedge clk); sel_lf = 0;
        cycles(2); lf_osc_en = 0;
        cycles(4);
        check(rst_pulses == p0, "R5", "no pulse at two cycles", rst_pulses - p0, 0);
        wait_idle("R3");
        @(negedge clk); lf_osc_en = 1;
        go_source(1);

        // R5: oscillator off without select change
        p0 = rst_pulses;
        @(negedge clk); lf_osc_en = 0;
        cycles(4);
        check(rst_pulses == p0, "R5", "no pulse without select change", rst_pulses - p0, 0);
        lf_osc_en = 1;
        cycles(2);

        // R6: pin function checks
        p0 = rst_pulses;
        osc_pin_fn = 0; cycles(1); hf_osc_en = 1;
        cycles(4);
        check(rst_pulses == p0 + 1, "R6", "pulse on enable with pins unset", rst_pulses - p0, 1);
        hf_osc_en = 0; osc_pin_fn = 1; cycles(2);
        p0 = rst_pulses;
        hf_osc_en = 1; cycles(4);
        check(rst_pulses == p0, "R6", "no pulse with pins set", rst_pulses - p0, 0);
        osc_pin_fn = 0; cycles(4);
        check(rst_pulses == p0, "R6", "no pulse when pins drop with enable held", rst_pulses - p0, 0);
        hf_osc_en = 0; osc_pin_fn = 1; cycles(2);

        // R9: pulse widths over the whole run
        check(min_high >= HALF_MIN, "R9", "shortest high phase", min_high, HALF_MIN);
        check(min_low >= HALF_MIN, "R9", "shortest low phase", min_low, HALF_MIN);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule